// File: doc/BRIEF.md
# Eight-Function Arithmetic Logic Unit

This block is an 8-bit arithmetic and logic unit. A 3-bit function code picks one of eight operations on two operands, `opnd_a` and `opnd_b`. The operations are addition, subtraction in either operand order, three bitwise operations and two constant patterns. A carry input feeds the arithmetic operations. The unit returns a result word and a single carry/borrow bit.

The adder and both subtractors are ripple chains. Each chain is built by replicating a 1-bit cell and passing the carry or borrow from the least significant bit upward. For the two subtraction codes, the carry input acts as the borrow into bit 0, and the carry output reports the borrow out of the top bit. The operation is selected combinationally. The result and the carry are registered on the rising clock edge, so each output appears one cycle after its inputs are sampled.

Top module: `alu8_unit`

## Requirements
- R1: When `rst` is high at a rising edge, `res_q` becomes all zeros and `carry_q` becomes 0 on that edge. This reset is synchronous and active high.
- R2: `res_q` and `carry_q` reflect the inputs sampled at the previous rising edge. They do not change between edges when the inputs change.
- R3: Code 3'b000 gives a result of all zeros and a carry of 0.
- R4: Code 3'b011 gives (A + B + carry_in) mod 256. The carry is bit 8 of that sum.
- R5: Code 3'b010 gives (A − B − carry_in) mod 256. The carry is the final borrow, which is 1 exactly when A < B + carry_in.
- R6: Code 3'b001 gives (B − A − carry_in) mod 256. The carry is the final borrow, which is 1 exactly when B < A + carry_in.
- R7: Code 3'b100 gives A XOR B, code 3'b101 gives A OR B, and code 3'b110 gives A AND B. The carry is 0 for all three.
- R8: Code 3'b111 gives a result with all eight bits set and a carry of 0.
- R9: For codes 000, 100, 101, 110 and 111, `carry_in` has no effect on either `res_q` or `carry_q`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| op_code | input | 3 | Function select |
| opnd_a | input | 8 | Operand A |
| opnd_b | input | 8 | Operand B |
| carry_in | input | 1 | Carry into the adder, or borrow into a subtractor |
| res_q | output | 8 | Registered result |
| carry_q | output | 1 | Registered carry or borrow out |

## Verification
The bench covers these corner cases:
- **Chain wraparound.** It uses 0xFF + 0x01 and the incoming carry on the adder. A chain that drops the carry out of a cell, or that ignores the carry input, shows a wrong bit 8.
- **Equal operands with a borrow in.** Both subtraction orders are run on equal operands with a borrow in, which must give 0xFF and a borrow out. A cell with a wrong borrow equation, or a unit that swaps the operand order of the two subtraction codes, gives a different value or borrow.
- **Logic and constant codes.** These are run with the carry input both low and high. A unit that leaks the carry input or a stale chain carry into the carry output gets caught.
- **Mid-stream reset.** A reset is applied while an operation is in flight. It must clear both outputs.
- **Latency.** Outputs must hold while the inputs change between edges. A design that passes values through without the register fails this check.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  localparam int unsigned ALU_WIDTH   = 8;
  localparam int unsigned FN_BITS     = 3;

  typedef enum logic [FN_BITS-1:0] {
    FN_ZERO  = 3'b000,
    FN_BSUBA = 3'b001,
    FN_ASUBB = 3'b010,
    FN_ADD   = 3'b011,
    FN_XOR   = 3'b100,
    FN_OR    = 3'b101,
    FN_AND   = 3'b110,
    FN_ONES  = 3'b111
  } alu_fn_e;

  // Arithmetic codes are the only ones that drive the carry output.
  function automatic logic fn_is_arith(input alu_fn_e fn);
    return (fn == FN_BSUBA) || (fn == FN_ASUBB) || (fn == FN_ADD);
  endfunction

endpackage

// File: rtl/alu_fa_cell.sv
module alu_fa_cell (
  input  logic x_i,
  input  logic y_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);

  logic half_sum;

  assign half_sum = x_i ^ y_i;
  assign s_o      = half_sum ^ c_i;
  assign c_o      = (c_i & half_sum) | (x_i & y_i);

endmodule

// File: rtl/alu_fs_cell.sv
module alu_fs_cell (
  input  logic m_i,   // minuend bit
  input  logic s_i,   // subtrahend bit
  input  logic p_i,   // borrow in
  output logic d_o,   // difference bit
  output logic p_o    // borrow out
);

  logic sub_mix;

  assign sub_mix = s_i ^ p_i;
  assign d_o     = m_i ^ sub_mix;
  assign p_o     = (~m_i & sub_mix) | (s_i & p_i);

endmodule

// File: rtl/alu_add_chain.sv
module alu_add_chain #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);

  logic [W:0] rip;

  assign rip[0] = cin_i;

  for (genvar k = 0; k < W; k++) begin : g_slice
    alu_fa_cell u_fa (
      .x_i (a_i[k]),
      .y_i (b_i[k]),
      .c_i (rip[k]),
      .s_o (sum_o[k]),
      .c_o (rip[k+1])
    );
  end

  assign cout_o = rip[W];

  // The ripple chain must match a plain W+1 bit sum.
  logic [W:0] chk_sum;
  always_comb begin
    chk_sum = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
    assert_add_chain_R4: assert ({cout_o, sum_o} == chk_sum);
  end

endmodule

// File: rtl/alu_sub_chain.sv
module alu_sub_chain #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] min_i,
  input  logic [W-1:0] sub_i,
  input  logic         bin_i,
  output logic [W-1:0] diff_o,
  output logic         bout_o
);

  logic [W:0] brw;

  assign brw[0] = bin_i;

  for (genvar k = 0; k < W; k++) begin : g_slice
    alu_fs_cell u_fs (
      .m_i (min_i[k]),
      .s_i (sub_i[k]),
      .p_i (brw[k]),
      .d_o (diff_o[k]),
      .p_o (brw[k+1])
    );
  end

  assign bout_o = brw[W];

  // The top bit of a W+1 bit two's complement difference is the final borrow.
  logic [W:0] chk_diff;
  always_comb begin
    chk_diff = {1'b0, min_i} - {1'b0, sub_i} - {{W{1'b0}}, bin_i};
    assert_sub_chain_R5: assert ({bout_o, diff_o} == chk_diff);
  end

endmodule

// File: rtl/alu8_unit.sv
module alu8_unit
  import alu8_pkg::*;
#(
  parameter int unsigned W = ALU_WIDTH
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [2:0]   op_code,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic         carry_in,
  output logic [W-1:0] res_q,
  output logic         carry_q
);

  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

  alu_fn_e fn;
  assign fn = alu_fn_e'(op_code);

  logic [W-1:0] add_sum, ab_diff, ba_diff;
  logic         add_co,  ab_bo,   ba_bo;

  alu_add_chain #(.W(W)) u_add (
    .a_i    (opnd_a),
    .b_i    (opnd_b),
    .cin_i  (carry_in),
    .sum_o  (add_sum),
    .cout_o (add_co)
  );

  // A - B
  alu_sub_chain #(.W(W)) u_sub_ab (
    .min_i  (opnd_a),
    .sub_i  (opnd_b),
    .bin_i  (carry_in),
    .diff_o (ab_diff),
    .bout_o (ab_bo)
  );

  // B - A
  alu_sub_chain #(.W(W)) u_sub_ba (
    .min_i  (opnd_b),
    .sub_i  (opnd_a),
    .bin_i  (carry_in),
    .diff_o (ba_diff),
    .bout_o (ba_bo)
  );

  logic [W-1:0] res_d;
  logic         arith_co;
  logic         carry_d;

  always_comb begin
    res_d    = '0;
    arith_co = 1'b0;
    unique case (fn)
      FN_ZERO:  res_d = '0;
      FN_BSUBA: begin res_d = ba_diff; arith_co = ba_bo;  end
      FN_ASUBB: begin res_d = ab_diff; arith_co = ab_bo;  end
      FN_ADD:   begin res_d = add_sum; arith_co = add_co; end
      FN_XOR:   res_d = opnd_a ^ opnd_b;
      FN_OR:    res_d = opnd_a | opnd_b;
      FN_AND:   res_d = opnd_a & opnd_b;
      FN_ONES:  res_d = ALL_ONES;
      default:  res_d = '0;
    endcase
    carry_d = fn_is_arith(fn) & arith_co;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q   <= '0;
      carry_q <= 1'b0;
    end else begin
      res_q   <= res_d;
      carry_q <= carry_d;
    end
  end

  // Assertions on the registered outputs
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (res_q == '0 && !carry_q));

  assert_zero_code_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_code) == 3'b000) |-> (res_q == '0 && !carry_q));

  assert_logic_no_carry_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_code[2])) |-> !carry_q);

  assert_xor_code_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_code) == 3'b100) |-> (res_q == ($past(opnd_a) ^ $past(opnd_b))));

  assert_ones_code_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_code) == 3'b111) |-> (res_q == ALL_ONES && !carry_q));

  assert_zero_carry_free_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_code) == 3'b000) |-> $stable(res_q) || $past(res_q) != '0 || res_q == '0);

endmodule

// File: tb/alu8_unit_tb_top.sv
module alu8_unit_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] op_code = 3'b000;
  logic [7:0] opnd_a = 8'h00;
  logic [7:0] opnd_b = 8'h00;
  logic       carry_in = 1'b0;
  logic [7:0] res_q;
  logic       carry_q;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  alu8_unit dut_i (
    .clk      (clk),
    .rst      (rst),
    .op_code  (op_code),
    .opnd_a   (opnd_a),
    .opnd_b   (opnd_b),
    .carry_in (carry_in),
    .res_q    (res_q),
    .carry_q  (carry_q)
  );

  // Reference model written from the requirements.
  function automatic logic [8:0] model(input logic [2:0] op, input logic [7:0] a,
                                       input logic [7:0] b, input logic ci);
    int sa, sb, r;
    sa = int'(a); sb = int'(b);
    case (op)
      3'b000: return 9'h000;
      3'b001: begin r = sb - sa - int'(ci); return {r < 0, r[7:0]}; end
      3'b010: begin r = sa - sb - int'(ci); return {r < 0, r[7:0]}; end
      3'b011: begin r = sa + sb + int'(ci); return {r > 255, r[7:0]}; end
      3'b100: return {1'b0, a ^ b};
      3'b101: return {1'b0, a | b};
      3'b110: return {1'b0, a & b};
      default: return {1'b0, 8'hFF};
    endcase
  endfunction

  task automatic compare(input string req, input logic [7:0] er, input logic ec);
    n_checks++;
    if (res_q !== er || carry_q !== ec) begin
      n_fails++;
      $display("FAIL %s: got res=%02h carry=%0b, expected res=%02h carry=%0b",
               req, res_q, carry_q, er, ec);
    end
  endtask

  // Drive at a falling edge, check after the following rising edge.
  task automatic apply(input string req, input logic [2:0] op, input logic [7:0] a,
                       input logic [7:0] b, input logic ci);
    logic [8:0] e;
    @(negedge clk);
    op_code = op; opnd_a = a; opnd_b = b; carry_in = ci;
    e = model(op, a, b, ci);
    @(negedge clk);
    compare(req, e[7:0], e[8]);
  endtask

  task automatic t_reset();
    @(negedge clk);
    compare("R1 reset state", 8'h00, 1'b0);
    rst = 1'b0;
  endtask

  task automatic t_constants();
    apply("R3 zero code", 3'b000, 8'hA5, 8'h5A, 1'b0);
    apply("R8 ones code", 3'b111, 8'h00, 8'h00, 1'b0);
    apply("R3 zero code with carry_in", 3'b000, 8'hFF, 8'hFF, 1'b1);
  endtask

  task automatic t_add();
    apply("R4 add simple", 3'b011, 8'h12, 8'h34, 1'b0);
    apply("R4 add wrap",   3'b011, 8'hFF, 8'h01, 1'b0);
    apply("R4 add cin",    3'b011, 8'hFF, 8'h00, 1'b1);
    apply("R4 add max",    3'b011, 8'hFF, 8'hFF, 1'b1);
  endtask

  task automatic t_sub_ab();
    apply("R5 a-b plain",         3'b010, 8'h50, 8'h20, 1'b0);
    apply("R5 a-b borrow",        3'b010, 8'h20, 8'h50, 1'b0);
    apply("R5 a-b equal, bin=1",  3'b010, 8'h77, 8'h77, 1'b1);
    apply("R5 a-b zero-zero",     3'b010, 8'h00, 8'h00, 1'b0);
  endtask

  task automatic t_sub_ba();
    apply("R6 b-a plain",         3'b001, 8'h20, 8'h50, 1'b0);
    apply("R6 b-a borrow",        3'b001, 8'h50, 8'h20, 1'b0);
    apply("R6 b-a equal, bin=1",  3'b001, 8'h3C, 8'h3C, 1'b1);
    apply("R6 b-a top bits",      3'b001, 8'h01, 8'h80, 1'b1);
  endtask

  task automatic t_logic();
    apply("R7 xor", 3'b100, 8'hF0, 8'hCC, 1'b0);
    apply("R7 or",  3'b101, 8'hF0, 8'h0C, 1'b0);
    apply("R7 and", 3'b110, 8'hF0, 8'h3C, 1'b0);
  endtask

  task automatic t_cin_ignored();
    logic [2:0] codes [5] = '{3'b000, 3'b100, 3'b101, 3'b110, 3'b111};
    foreach (codes[i]) begin
      apply("R9 carry_in high, no effect", codes[i], 8'hFF, 8'h81, 1'b1);
      apply("R9 carry_in low, same result", codes[i], 8'hFF, 8'h81, 1'b0);
    end
  endtask

  task automatic t_latency();
    logic [8:0] e;
    apply("R2 first op", 3'b011, 8'h10, 8'h01, 1'b0);
    e = model(3'b011, 8'h10, 8'h01, 1'b0);
    @(negedge clk);
    op_code = 3'b111; opnd_a = 8'h00; opnd_b = 8'h00; carry_in = 1'b1;
    #2;
    compare("R2 holds between edges", e[7:0], e[8]);
    @(negedge clk);
    compare("R2 new value after edge", 8'hFF, 1'b0);
  endtask

  task automatic t_reset_mid();
    @(negedge clk);
    op_code = 3'b011; opnd_a = 8'hFF; opnd_b = 8'hFF; carry_in = 1'b1;
    rst = 1'b1;
    @(negedge clk);
    compare("R1 reset mid-stream", 8'h00, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    compare("R4 after reset release", 8'hFF, 1'b1);
  endtask

  task automatic t_sweep();
    logic [7:0] lfsr = 8'hB7;
    logic [7:0] a;
    for (int i = 0; i < 64; i++) begin
      a    = lfsr;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      apply("R4 R5 R6 R7 sweep", 3'(i % 8), a, lfsr, lfsr[0] ^ a[3]);
    end
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    t_constants();
    t_add();
    t_sub_ab();
    t_sub_ba();
    t_logic();
    t_cin_ignored();
    t_latency();
    t_reset_mid();
    t_sweep();
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: got timeout, expected completion");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule